// File: doc/BRIEF.md
# E1 Time-Slot 0 Transmit Multiplexer

This block builds the eight bits of time-slot 0 of each outgoing E1 frame. A transmit timing counter gives the frame type (alignment or non-alignment), the time-slot index and the bit index. The block uses these to decide, bit by bit, whether the serial output comes from internal generation or from the incoming transmit data stream. Internally generated bits are the fixed alignment pattern, the fixed non-alignment bit 2, the Si bits from two register bits, the A bit from a register bit or from an automatic alarm source, and the Sa4 to Sa8 bits from a 5-bit register field.

The fields can be made transparent in two ways. A full-transparency control passes the whole slot through unchanged. A per-field mask passes only the Si, A or Sa fields through. The control values are captured when bit 1 of time-slot 0 arrives and are held for the rest of the slot, so a field never changes partway through the slot. Every other time slot passes through untouched. The output is registered, with one cycle of latency.

Top module: `e1_ts0_tx_mux`

## Requirements
- R1: Outside time-slot 0 (`ts_idx_i != 0`), `tx_data_o` equals `tx_data_i` as it was one cycle earlier.
- R2: While `rst_ni` is low, `tx_data_o` is 0.
- R3: In an alignment frame (`frame_fas_i = 1`) without full transparency, bit indices 1 to 7 (bits 2 to 8 of the slot) carry the pattern 0,0,1,1,0,1,1 in that order.
- R4: With full transparency (`full_transp_i = 1`), all eight bits of time-slot 0 equal the input data delayed by one cycle, whatever the frame type and mask.
- R5: Bit index 0 is the Si bit. It comes from `si_fas_i` in alignment frames and from `si_nfas_i` in non-alignment frames, or from the input stream when `mask_si_i = 1`.
- R6: In a non-alignment frame without full transparency, bit index 1 is always 1, whatever the mask bits and the input data.
- R7: In a non-alignment frame, bit index 2 is the A bit. It comes from the input stream when `mask_a_i = 1`. Otherwise it equals `rx_unsync_i` when `auto_a_i = 1`, and `a_bit_i` when `auto_a_i = 0`.
- R8: In a non-alignment frame, bit indices 3 to 7 are Sa4 to Sa8 and take `sa_bits_i[4]` down to `sa_bits_i[0]` in that order. They come from the input stream when `mask_sa_i = 1`.
- R9: All control and register inputs are captured at bit index 0 of time-slot 0. A change at bit indices 1 to 7 of the same slot has no effect on the output of that slot.
- R10: Each output bit appears on `tx_data_o` exactly one clock after its position and data are presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| frame_fas_i | input | 1 | 1 = alignment frame, 0 = non-alignment frame |
| ts_idx_i | input | 5 | Time-slot index within the frame |
| bit_idx_i | input | 3 | Bit index in the slot, 0 = first bit sent |
| tx_data_i | input | 1 | Serial transmit data in |
| full_transp_i | input | 1 | Pass the whole of time-slot 0 through |
| mask_si_i | input | 1 | Pass the Si bits through |
| mask_a_i | input | 1 | Pass the A bit through |
| mask_sa_i | input | 1 | Pass Sa4 to Sa8 through |
| si_fas_i | input | 1 | Si value for alignment frames |
| si_nfas_i | input | 1 | Si value for non-alignment frames |
| a_bit_i | input | 1 | A bit register value |
| auto_a_i | input | 1 | Drive A from the receiver sync state |
| rx_unsync_i | input | 1 | Receiver not synchronized |
| sa_bits_i | input | 5 | Sa4..Sa8 values, bit 4 = Sa4 |
| tx_data_o | output | 1 | Serial transmit data out |

## Verification
The bench tries every combination of the nine single-bit controls in both frame types. Each slot uses its own data byte, so a passed-through bit can be told apart from a generated one, and the per-field masks can be told apart from one another. Each combination runs twice. In the second run every control and the Sa field are inverted from bit index 1 onward, which exposes any control that is sampled live instead of held for the slot. Bits of time-slot 1 follow each slot and confirm plain pass-through and the one-cycle latency.

// File: rtl/e1_ts0_pkg.sv
package e1_ts0_pkg;
  localparam int SA_W = 5;

  typedef enum logic [2:0] {
    FLD_SI,
    FLD_FRAME,
    FLD_FIX1,
    FLD_A,
    FLD_SA
  } field_e;

  typedef struct packed {
    logic            full;
    logic            m_si;
    logic            m_a;
    logic            m_sa;
    logic            auto_a;
    logic            unsync;
    logic            si_fas;
    logic            si_nfas;
    logic            a_bit;
    logic [SA_W-1:0] sa;
  } ts0_cfg_t;
endpackage

// File: rtl/e1_ts0_cfg_hold.sv
module e1_ts0_cfg_hold
  import e1_ts0_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     start_i,
  input  ts0_cfg_t cfg_i,
  output ts0_cfg_t cfg_o
);
  ts0_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cfg_q <= '0;
    else if (start_i) cfg_q <= cfg_i;
  end

  // first bit of the slot uses live values, the rest the held copy
  assign cfg_o = start_i ? cfg_i : cfg_q;
endmodule

// File: rtl/e1_ts0_field_dec.sv
module e1_ts0_field_dec
  import e1_ts0_pkg::*;
#(
  parameter int BIT_W = 3
) (
  input  logic             fas_i,
  input  logic [BIT_W-1:0] bit_i,
  output field_e           field_o
);
  localparam int SA_LO = 3;

  always_comb begin
    if (bit_i == '0)             field_o = FLD_SI;
    else if (fas_i)              field_o = FLD_FRAME;
    else if (bit_i == BIT_W'(1)) field_o = FLD_FIX1;
    else if (bit_i == BIT_W'(2)) field_o = FLD_A;
    else if (int'(bit_i) >= SA_LO) field_o = FLD_SA;
    else                         field_o = FLD_FIX1;
  end
endmodule

// File: rtl/e1_ts0_bit_gen.sv
module e1_ts0_bit_gen
  import e1_ts0_pkg::*;
#(
  parameter int         BIT_W   = 3,
  parameter logic [6:0] FAS_PAT = 7'b0011011
) (
  input  field_e           field_i,
  input  logic             fas_i,
  input  logic [BIT_W-1:0] bit_i,
  input  logic             data_i,
  input  ts0_cfg_t         cfg_i,
  output logic             bit_o
);
  localparam int LAST = (1 << BIT_W) - 1;

  logic int_bit;
  logic transp;
  logic [BIT_W-1:0] rev;

  assign rev = BIT_W'(LAST) - bit_i;

  always_comb begin
    int_bit = 1'b1;
    transp  = 1'b0;
    unique case (field_i)
      FLD_SI: begin
        int_bit = fas_i ? cfg_i.si_fas : cfg_i.si_nfas;
        transp  = cfg_i.m_si;
      end
      FLD_FRAME: int_bit = FAS_PAT[rev];
      FLD_FIX1:  int_bit = 1'b1;
      FLD_A: begin
        int_bit = cfg_i.auto_a ? cfg_i.unsync : cfg_i.a_bit;
        transp  = cfg_i.m_a;
      end
      FLD_SA: begin
        int_bit = cfg_i.sa[rev[2:0]];
        transp  = cfg_i.m_sa;
      end
      default: int_bit = 1'b1;
    endcase
    bit_o = (cfg_i.full || transp) ? data_i : int_bit;
  end
endmodule

// File: rtl/e1_ts0_tx_mux.sv
module e1_ts0_tx_mux
  import e1_ts0_pkg::*;
#(
  parameter int         TS_W    = 5,
  parameter int         BIT_W   = 3,
  parameter logic [6:0] FAS_PAT = 7'b0011011
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            frame_fas_i,
  input  logic [TS_W-1:0] ts_idx_i,
  input  logic [BIT_W-1:0] bit_idx_i,
  input  logic            tx_data_i,
  input  logic            full_transp_i,
  input  logic            mask_si_i,
  input  logic            mask_a_i,
  input  logic            mask_sa_i,
  input  logic            si_fas_i,
  input  logic            si_nfas_i,
  input  logic            a_bit_i,
  input  logic            auto_a_i,
  input  logic            rx_unsync_i,
  input  logic [SA_W-1:0] sa_bits_i,
  output logic            tx_data_o
);
  logic     in_ts0;
  logic     slot_start;
  ts0_cfg_t cfg_live;
  ts0_cfg_t cfg_eff;
  field_e   field;
  logic     gen_bit;
  logic     out_d;

  assign in_ts0     = (ts_idx_i == '0);
  assign slot_start = in_ts0 && (bit_idx_i == '0);

  assign cfg_live = '{full:    full_transp_i,
                      m_si:    mask_si_i,
                      m_a:     mask_a_i,
                      m_sa:    mask_sa_i,
                      auto_a:  auto_a_i,
                      unsync:  rx_unsync_i,
                      si_fas:  si_fas_i,
                      si_nfas: si_nfas_i,
                      a_bit:   a_bit_i,
                      sa:      sa_bits_i};

  e1_ts0_cfg_hold u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (slot_start),
    .cfg_i   (cfg_live),
    .cfg_o   (cfg_eff)
  );

  e1_ts0_field_dec #(.BIT_W(BIT_W)) u_dec (
    .fas_i   (frame_fas_i),
    .bit_i   (bit_idx_i),
    .field_o (field)
  );

  e1_ts0_bit_gen #(.BIT_W(BIT_W), .FAS_PAT(FAS_PAT)) u_gen (
    .field_i (field),
    .fas_i   (frame_fas_i),
    .bit_i   (bit_idx_i),
    .data_i  (tx_data_i),
    .cfg_i   (cfg_eff),
    .bit_o   (gen_bit)
  );

  assign out_d = in_ts0 ? gen_bit : tx_data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tx_data_o <= 1'b0;
    else         tx_data_o <= out_d;
  end
endmodule

// File: rtl/e1_ts0_tx_mux_chk.sv
module e1_ts0_tx_mux_chk
  import e1_ts0_pkg::*;
#(
  parameter int         TS_W    = 5,
  parameter int         BIT_W   = 3,
  parameter logic [6:0] FAS_PAT = 7'b0011011
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             frame_fas_i,
  input logic [TS_W-1:0]  ts_idx_i,
  input logic [BIT_W-1:0] bit_idx_i,
  input logic             tx_data_i,
  input logic             tx_data_o,
  input ts0_cfg_t         cfg_eff
);
  localparam int LAST = (1 << BIT_W) - 1;

  p_passthru_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ts_idx_i != '0) |=> (tx_data_o == $past(tx_data_i)));

  p_reset_r2: assert property (@(posedge clk_i)
    !rst_ni |-> (tx_data_o == 1'b0));

  p_fas_pat_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ts_idx_i == '0 && frame_fas_i && bit_idx_i != '0 && !cfg_eff.full)
      |=> (tx_data_o == FAS_PAT[BIT_W'(LAST) - $past(bit_idx_i)]));

  p_full_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ts_idx_i == '0 && cfg_eff.full) |=> (tx_data_o == $past(tx_data_i)));

  p_nfas_one_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ts_idx_i == '0 && !frame_fas_i && bit_idx_i == BIT_W'(1) && !cfg_eff.full)
      |=> tx_data_o);

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ts_idx_i == '0 && bit_idx_i != '0) |-> (cfg_eff == $past(cfg_eff)));
endmodule

bind e1_ts0_tx_mux e1_ts0_tx_mux_chk #(.TS_W(TS_W), .BIT_W(BIT_W), .FAS_PAT(FAS_PAT)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .frame_fas_i (frame_fas_i),
  .ts_idx_i    (ts_idx_i),
  .bit_idx_i   (bit_idx_i),
  .tx_data_i   (tx_data_i),
  .tx_data_o   (tx_data_o),
  .cfg_eff     (cfg_eff)
);

// File: tb/e1_ts0_tx_mux_bench.sv
`timescale 1ns/1ps
module e1_ts0_tx_mux_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fas = 1'b0;
  logic [4:0] ts = '0;
  logic [2:0] bi = '0;
  logic       din = 1'b0;
  logic       full = 1'b0, msi = 1'b0, ma = 1'b0, msa = 1'b0;
  logic       sif = 1'b0, sin = 1'b0, ar = 1'b0, aut = 1'b0, uns = 1'b0;
  logic [4:0] sa = '0;
  logic       dout;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  e1_ts0_tx_mux u_e1_ts0_tx_mux (
    .clk_i(clk), .rst_ni(rst_n), .frame_fas_i(fas), .ts_idx_i(ts), .bit_idx_i(bi),
    .tx_data_i(din), .full_transp_i(full), .mask_si_i(msi), .mask_a_i(ma),
    .mask_sa_i(msa), .si_fas_i(sif), .si_nfas_i(sin), .a_bit_i(ar),
    .auto_a_i(aut), .rx_unsync_i(uns), .sa_bits_i(sa), .tx_data_o(dout)
  );

  task automatic check(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic drive_cfg(input logic [8:0] c, input logic [4:0] s);
    full = c[0]; msi = c[1]; ma = c[2]; msa = c[3]; aut = c[4];
    uns = c[5]; sif = c[6]; sin = c[7]; ar = c[8]; sa = s;
  endtask

  // expected slot bit from the requirements; tag names the governing one
  function automatic logic exp_bit(input logic [8:0] c, input logic f, input int k,
                                   input logic d, input logic [4:0] s, output string tag);
    logic [6:0] pat = 7'b0011011;
    if (c[0]) begin tag = "R4"; return d; end
    if (k == 0) begin tag = "R5"; return c[1] ? d : (f ? c[6] : c[7]); end
    if (f) begin tag = "R3"; return pat[7 - k]; end
    if (k == 1) begin tag = "R6"; return 1'b1; end
    if (k == 2) begin tag = "R7"; return c[2] ? d : (c[4] ? c[5] : c[8]); end
    tag = "R8";
    return c[3] ? d : s[7 - k];
  endfunction

  initial begin
    #400000;
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [4:0] s;
    logic [7:0] db;
    logic       pend;
    logic       pexp;
    string      ptag;
    string      t;
    repeat (3) @(negedge clk);
    check(dout, 1'b0, "R2 reset");
    @(negedge clk);
    rst_n = 1'b1;
    pend = 1'b0; pexp = 1'b0; ptag = "";
    for (int c = 0; c < 512; c++) begin
      for (int f = 0; f < 2; f++) begin
        for (int m = 0; m < 2; m++) begin
          s  = 5'((c * 7 + f * 3 + m * 11) & 31);
          db = 8'((c * 37 + f * 91 + m * 53) & 255);
          for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (pend) check(dout, pexp, ptag);
            fas = f[0];
            if (k < 8) begin
              ts = 5'd0; bi = 3'(k); din = db[7 - k];
              if (k == 0 || m == 0) drive_cfg(9'(c), s);
              else drive_cfg(~9'(c), ~s);  // R9: mid-slot change ignored
              pexp = exp_bit(9'(c), f[0], k, din, s, t);
              ptag = (m == 1 && k > 0) ? {t, "/R9/R10"} : {t, "/R10"};
            end else begin
              ts = 5'd1; bi = 3'(k - 8); din = db[k - 8] ^ 1'b1;
              drive_cfg(~9'(c), ~s);
              pexp = din;
              ptag = "R1";
            end
            pend = 1'b1;
          end
        end
      end
    end
    @(negedge clk);
    if (pend) check(dout, pexp, ptag);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule